// File: doc/BRIEF.md
# FPGA Serial-Free Configuration Byte Streamer

This block loads an older-style FPGA through its byte-wide slave configuration port. A `start` pulse begins a load. The block pulls the active-low program pin low for a fixed number of clocks, then releases it. It waits, with a programmable limit, for the active-low init pin to read high. It then writes a fixed header to the target, followed by the raw bitstream. The bitstream arrives from a valid/ready byte source that marks its final byte with an end flag.

The block cuts the payload into fixed-size frames. Each frame goes out with a leading preamble code, a trailing check code and a fixed run of padding writes. A frame is only started while the target still reports init high and done low and the source has payload left. After the last frame, four startup bytes are written. The block then reports either a good load (done high, init never dropped) or a failure. A failure caused by init never rising is also marked as a timeout.

Every byte reaches the target as a single-clock write strobe. The data is held steady on the bus for that clock and the idle clock after it. The init and done pins pass through two-flop synchronizers before the block uses them.

Top module: `cfg_streamer`

## Requirements
- R1: After `start` is sampled in idle, `cfg_prog_n` goes low for exactly `PROG_LOW_CYCLES` clocks and then returns high. `cfg_prog_n` is high out of reset.
- R2: No byte is written before the synchronized init pin reads high. If it has not read high `init_timeout` clocks after `cfg_prog_n` rises, the load ends with `load_fail` and `fail_timeout` set and no byte written.
- R3: The header is written first, in this order: 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R4: Each frame is written as 0x4F, then `FRAME_BYTES` payload bytes in source order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R5: A frame starts only if, at the frame boundary, init is high, done is low, init has not dropped since the header began, and the byte flagged `s_last` has not yet been taken. Otherwise no further frame is written.
- R6: After the frame loop ends, exactly four 0xFF startup bytes are written, whatever the reason the loop ended.
- R7: If `s_last` arrives before a frame is full, the rest of that frame's payload slots are written as 0xFF and no more source bytes are taken.
- R8: `s_ready` is high only when the next byte written will be a payload slot taken from the source. Framing bytes are never written while the source is ready. Source stalls delay the stream without inserting bytes.
- R9: When a load completes, `load_ok` is set if done reads high after the startup bytes and init never dropped during streaming; otherwise `load_fail` is set. The two are never set together. `busy` falls in the same cycle the result appears.
- R10: `cfg_wr` is never high two clocks in a row, and `cfg_data` holds its value through the clock after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load when idle |
| init_timeout | input | TO_W | Maximum clocks to wait for init high |
| s_data | input | 8 | Bitstream byte from source |
| s_valid | input | 1 | Source byte valid |
| s_last | input | 1 | Marks the final source byte |
| s_ready | output | 1 | Block accepts a source byte |
| cfg_prog_n | output | 1 | Active-low program pin to target |
| cfg_init_n | input | 1 | Active-low init pin from target (high = ready) |
| cfg_done | input | 1 | Done pin from target |
| cfg_wr | output | 1 | Single-clock write strobe |
| cfg_data | output | 8 | Configuration data bus |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load succeeded |
| load_fail | output | 1 | Last load failed |
| fail_timeout | output | 1 | Last load failed waiting for init |

## Verification
The program pulse is measured by counting falling clock edges from the one just after `start` is taken until `cfg_prog_n` reads high; the count must equal `PROG_LOW_CYCLES`. The timeout result is due exactly `init_timeout` clocks after the program pin rises, and the bench counts falling edges over that same window. Written bytes are captured on the falling edge while `cfg_wr` is high, so each strobe is seen once, and are compared in order against a stream the bench builds from the frame rules. The result flags are read on the first falling edge with `busy` low, since that is the same cycle they are set. The bench raises done and drops init at chosen byte counts, far from any frame boundary, so the two-clock synchronizer delay cannot change which frames are expected.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int BYTE_W      = 8;
    localparam int HDR_LEN     = 8;
    localparam int TAIL_LEN    = 6;
    localparam int STARTUP_LEN = 4;

    localparam logic [BYTE_W-1:0] C_PREAMBLE = 8'h4F;
    localparam logic [BYTE_W-1:0] C_CHECK    = 8'h4B;
    localparam logic [BYTE_W-1:0] C_FILL     = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT,
        ST_HDR,
        ST_PRE,
        ST_PAY,
        ST_TAIL,
        ST_START,
        ST_FIN
    } st_e;

    typedef enum logic [1:0] {
        K_HDR,
        K_PRE,
        K_TAIL,
        K_STARTUP
    } code_kind_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], din};
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cfg_code_table.sv
module cfg_code_table
    import cfg_stream_pkg::*;
(
    input  code_kind_e        kind,
    input  logic [2:0]        idx,
    output logic [BYTE_W-1:0] code
);
    always_comb begin
        code = C_FILL;
        unique case (kind)
            K_HDR: begin
                unique case (idx)
                    3'd3:    code = C_PREAMBLE;
                    3'd4:    code = 8'h80;
                    3'd5:    code = 8'hAF;
                    3'd6:    code = 8'h9B;
                    3'd7:    code = C_CHECK;
                    default: code = C_FILL;
                endcase
            end
            K_PRE:     code = C_PREAMBLE;
            K_TAIL:    code = (idx == 3'd0 || idx == 3'd2) ? C_CHECK : C_FILL;
            K_STARTUP: code = C_FILL;
            default:   code = C_FILL;
        endcase
    end
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
    import cfg_stream_pkg::*;
#(
    parameter int PROG_LOW_CYCLES = 500,
    parameter int FRAME_BYTES     = 21,
    parameter int TO_W            = 16,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TO_W-1:0]   init_timeout,
    input  logic [7:0]        s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic              cfg_prog_n,
    input  logic              cfg_init_n,
    input  logic              cfg_done,
    output logic              cfg_wr,
    output logic [7:0]        cfg_data,
    output logic              busy,
    output logic              load_ok,
    output logic              load_fail,
    output logic              fail_timeout
);
    localparam int PW      = $clog2(PROG_LOW_CYCLES + 1);
    localparam int CNT_W   = (PW > TO_W) ? PW : TO_W;
    localparam int CW1     = CNT_W + 1;
    localparam int IDX_MAX = (FRAME_BYTES > HDR_LEN) ? FRAME_BYTES : HDR_LEN;
    localparam int IDX_W   = $clog2(IDX_MAX);

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              hold;
        logic              last_seen;
        logic              lost;
        logic              prog_n;
        logic              wr;
        logic [BYTE_W-1:0] data;
        logic              ok;
        logic              fail;
        logic              tmo;
    } regs_t;

    regs_t q, d;

    logic [1:0]        pins_s;
    logic              init_s;
    logic              done_s;
    code_kind_e        kind;
    logic [BYTE_W-1:0] code;
    logic [CW1-1:0]    waited;

    cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cfg_done, cfg_init_n}),
        .dout  (pins_s)
    );
    assign init_s = pins_s[0];
    assign done_s = pins_s[1];

    always_comb begin
        unique case (q.st)
            ST_HDR:   kind = K_HDR;
            ST_TAIL:  kind = K_TAIL;
            ST_START: kind = K_STARTUP;
            default:  kind = K_PRE;
        endcase
    end

    cfg_code_table u_codes (
        .kind (kind),
        .idx  (q.idx[2:0]),
        .code (code)
    );

    assign waited  = {1'b0, q.cnt} + CW1'(1);
    assign s_ready = (q.st == ST_PAY) && !q.hold && !q.last_seen;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if ((q.st == ST_HDR || q.st == ST_PRE || q.st == ST_PAY || q.st == ST_TAIL) && !init_s) begin
            d.lost = 1'b1;
        end
        if (q.hold) begin
            d.hold = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (start) begin
                        d.st        = ST_PROG;
                        d.cnt       = '0;
                        d.prog_n    = 1'b0;
                        d.ok        = 1'b0;
                        d.fail      = 1'b0;
                        d.tmo       = 1'b0;
                        d.lost      = 1'b0;
                        d.last_seen = 1'b0;
                    end
                end
                ST_PROG: begin
                    if (q.cnt == CNT_W'(PROG_LOW_CYCLES - 1)) begin
                        d.prog_n = 1'b1;
                        d.st     = ST_WAIT;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (init_s) begin
                        d.st  = ST_HDR;
                        d.idx = '0;
                    end else if (waited >= CW1'(init_timeout)) begin
                        d.st   = ST_IDLE;
                        d.fail = 1'b1;
                        d.tmo  = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_HDR: begin
                    d.wr   = 1'b1;
                    d.data = code;
                    d.hold = 1'b1;
                    if (q.idx == IDX_W'(HDR_LEN - 1)) d.st = ST_PRE;
                    else d.idx = q.idx + IDX_W'(1);
                end
                ST_PRE: begin
                    d.idx = '0;
                    if (init_s && !q.lost && !done_s && !q.last_seen) begin
                        d.wr   = 1'b1;
                        d.data = code;
                        d.hold = 1'b1;
                        d.st   = ST_PAY;
                    end else begin
                        d.st = ST_START;
                    end
                end
                ST_PAY: begin
                    if (q.last_seen || s_valid) begin
                        d.wr   = 1'b1;
                        d.hold = 1'b1;
                        d.data = q.last_seen ? C_FILL : s_data;
                        if (!q.last_seen && s_last) d.last_seen = 1'b1;
                        if (q.idx == IDX_W'(FRAME_BYTES - 1)) begin
                            d.st  = ST_TAIL;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end
                end
                ST_TAIL: begin
                    d.wr   = 1'b1;
                    d.data = code;
                    d.hold = 1'b1;
                    if (q.idx == IDX_W'(TAIL_LEN - 1)) d.st = ST_PRE;
                    else d.idx = q.idx + IDX_W'(1);
                end
                ST_START: begin
                    d.wr   = 1'b1;
                    d.data = code;
                    d.hold = 1'b1;
                    if (q.idx == IDX_W'(STARTUP_LEN - 1)) d.st = ST_FIN;
                    else d.idx = q.idx + IDX_W'(1);
                end
                ST_FIN: begin
                    d.st = ST_IDLE;
                    if (done_s && !q.lost) d.ok = 1'b1;
                    else d.fail = 1'b1;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.prog_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cfg_prog_n   = q.prog_n;
    assign cfg_wr       = q.wr;
    assign cfg_data     = q.data;
    assign busy         = (q.st != ST_IDLE);
    assign load_ok      = q.ok;
    assign load_fail    = q.fail;
    assign fail_timeout = q.tmo;
endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk #(
    parameter int PROG_LOW_CYCLES = 500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_prog_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_data,
    input logic       s_ready,
    input logic       busy,
    input logic       load_ok,
    input logic       load_fail,
    input logic       fail_timeout
);
    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt <= '0;
        else if (!cfg_prog_n) low_cnt <= low_cnt + 32'd1;
        else low_cnt <= '0;
    end

    p_prog_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_prog_n) |-> (low_cnt == 32'(PROG_LOW_CYCLES)));

    p_no_wr_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> !cfg_wr);

    p_tmo_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fail_timeout |-> load_fail);

    p_ready_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !cfg_wr);

    p_result_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && load_fail));

    p_idle_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok || load_fail) |-> !busy);

    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !cfg_wr);

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(cfg_data));
endmodule

bind cfg_streamer cfg_streamer_chk #(.PROG_LOW_CYCLES(PROG_LOW_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_prog_n   (cfg_prog_n),
    .cfg_wr       (cfg_wr),
    .cfg_data     (cfg_data),
    .s_ready      (s_ready),
    .busy         (busy),
    .load_ok      (load_ok),
    .load_fail    (load_fail),
    .fail_timeout (fail_timeout)
);

// File: tb/cfg_streamer_bench.sv
module cfg_streamer_bench;
    localparam int PLC  = 10;
    localparam int FB   = 21;
    localparam int TO_W = 16;
    localparam int TMO  = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [TO_W-1:0] init_timeout = TO_W'(TMO);
    logic [7:0]      s_data = '0;
    logic            s_valid = 1'b0;
    logic            s_last = 1'b0;
    logic            s_ready;
    logic            cfg_prog_n;
    logic            cfg_init_n = 1'b0;
    logic            cfg_done = 1'b0;
    logic            cfg_wr;
    logic [7:0]      cfg_data;
    logic            busy, load_ok, load_fail, fail_timeout;

    always #10 clk = ~clk;

    cfg_streamer #(.PROG_LOW_CYCLES(PLC), .FRAME_BYTES(FB), .TO_W(TO_W)) u_cfg_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .init_timeout(init_timeout),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .busy(busy),
        .load_ok(load_ok), .load_fail(load_fail), .fail_timeout(fail_timeout)
    );

    int n_chk = 0, n_fail = 0;
    bit ended = 0;

    int src_len = 0, src_idx = 0, cyc = 0, wcnt = 0, ready_bad = 0, exp_n = 0;
    bit src_en = 0, src_gap = 0, hs_pend = 0;
    logic [7:0] cap  [256];
    logic [7:0] expb [256];
    bit         is_pay [256];

    function automatic logic [7:0] pat(int i);
        return 8'((i * 29 + 7) ^ (i / 8));
    endfunction

    task automatic check(bit cond, string req, string what, int act, int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // source model and write capture, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cfg_wr) begin
            if (wcnt < 256) cap[wcnt] = cfg_data;
            wcnt++;
        end
        if (hs_pend) src_idx++;
        s_valid = src_en && (src_idx < src_len) && (!src_gap || (cyc % 3 != 0));
        s_data  = pat(src_idx);
        s_last  = (src_idx == src_len - 1);
        if (s_ready && !((wcnt < 256) && is_pay[wcnt])) ready_bad++;
        hs_pend = s_valid && s_ready;
    end

    task automatic push(logic [7:0] b, bit pay);
        expb[exp_n]   = b;
        is_pay[exp_n] = pay;
        exp_n++;
    endtask

    task automatic build_expected(int nfr, int len);
        exp_n = 0;
        for (int k = 0; k < 256; k++) is_pay[k] = 0;
        push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0); push(8'h4F, 0);
        push(8'h80, 0); push(8'hAF, 0); push(8'h9B, 0); push(8'h4B, 0);
        for (int f = 0; f < nfr; f++) begin
            push(8'h4F, 0);
            for (int j = 0; j < FB; j++) begin
                int ix = f * FB + j;
                push((ix < len) ? pat(ix) : 8'hFF, 1);
            end
            push(8'h4B, 0); push(8'hFF, 0); push(8'h4B, 0);
            push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0);
        end
        for (int k = 0; k < 4; k++) push(8'hFF, 0);
    endtask

    task automatic pulse_and_measure(string tag);
        int low;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        low = 0;
        while (!cfg_prog_n && low < 100000) begin
            low++;
            @(negedge clk);
        end
        check(low == PLC, "R1", {tag, " program pin low width"}, low, PLC);
    endtask

    task automatic run(string tag, int len, bit gap, int done_at, int drop_at, int nfr, bit exp_ok);
        int guard, bad;
        cfg_init_n = 1'b0; cfg_done = 1'b0;
        src_len = len; src_idx = 0; src_gap = gap; hs_pend = 0; src_en = 1;
        wcnt = 0; ready_bad = 0;
        build_expected(nfr, len);
        pulse_and_measure(tag);
        repeat (15) @(negedge clk);
        check(wcnt == 0, "R2", {tag, " writes before init high"}, wcnt, 0);
        cfg_init_n = 1'b1;
        guard = 0;
        while (busy && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (done_at >= 0 && wcnt >= done_at) cfg_done = 1'b1;
            if (drop_at >= 0 && wcnt >= drop_at) cfg_init_n = 1'b0;
        end
        // R5 frame gating and R6 startup count show up in the byte total
        check(wcnt == exp_n, "R5 R6", {tag, " byte count"}, wcnt, exp_n);
        bad = -1;
        for (int k = 0; k < exp_n; k++) if (bad < 0 && cap[k] !== expb[k]) bad = k;
        check(bad < 0, "R3 R4 R7", $sformatf("%s stream byte at %0d", tag, bad),
              (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expb[bad]));
        check(ready_bad == 0, "R8", {tag, " ready outside payload slot"}, ready_bad, 0);
        check(load_ok == exp_ok, "R9", {tag, " load_ok"}, int'(load_ok), int'(exp_ok));
        check(load_fail == !exp_ok, "R9", {tag, " load_fail"}, int'(load_fail), int'(!exp_ok));
        check(fail_timeout == 1'b0, "R2", {tag, " no timeout"}, int'(fail_timeout), 0);
        src_en = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_timeout();
        int c;
        cfg_init_n = 1'b0; cfg_done = 1'b0;
        src_en = 0; wcnt = 0;
        pulse_and_measure("T");
        c = 0;
        while (!load_fail && c < 1000) begin
            @(negedge clk);
            c++;
        end
        check(c == TMO, "R2", "T timeout latency", c, TMO);
        check(fail_timeout == 1'b1, "R2", "T timeout flag", int'(fail_timeout), 1);
        check(wcnt == 0, "R2", "T no writes on timeout", wcnt, 0);
        check(load_ok == 1'b0 && !busy, "R9", "T ok low and idle", int'(load_ok), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_prog_n == 1'b1, "R1", "reset program pin", int'(cfg_prog_n), 1);
        check(cfg_wr == 1'b0, "R10", "reset strobe", int'(cfg_wr), 0);
        check(busy == 1'b0 && s_ready == 1'b0, "R8", "reset busy/ready", int'(busy), 0);
        check(load_ok == 1'b0 && load_fail == 1'b0, "R9", "reset result", int'(load_ok | load_fail), 0);

        run("A", 42, 0, 64, -1, 2, 1);   // two full frames, good load
        run("B", 30, 1, 64, -1, 2, 1);   // R7 short last frame, stalled source
        run("C", 42, 0, 20, -1, 1, 1);   // R5 done high early ends loop
        run("D", 42, 0, -1, 20, 1, 0);   // R9 init dropped mid stream
        run("E", 21, 0, -1, -1, 1, 0);   // R5 exact frame, done never high
        run_timeout();
        finish_up();
    end
endmodule